// File: doc/BRIEF.md
# Progressive-Precision Bit-Serial MAC Column

This block is one column of an inference datapath. The weights are stored as sequences of signed binary digits, and each digit stands for +1 or -1. The column has eight lanes. Each lane holds an 8-bit two's-complement activation and receives one weight digit per step. A lane passes its activation unchanged when its digit stands for +1 and negates it when the digit stands for -1. The eight lane values are summed, the sum is shifted left by the place value of the current digit, and the shifted sum is added into a 22-bit signed accumulator.

Digits arrive from the most significant position downward. A run is opened with a start pulse, which clears the accumulator and captures two settings: the stored weight width N and the precision M actually used. The column then consumes M digit steps with shifts N-1, N-2, ..., N-M and stops. The result is therefore the product sum of a coarser M-bit weight, taken from the same stored digits. When the final digit has been absorbed, a result-valid strobe is raised for one cycle, and the accumulator value stays on the result port until the next start.

Top module: `bitserial_mac_column`

## Requirements
- R1: Lane i takes its activation from `acts[8*i+7:8*i]` and its digit from `dig_bits[i]`. A digit of 1 contributes +activation and a digit of 0 contributes -activation. An activation of -128 with digit 0 contributes +128, with no wrap.
- R2: Step k of a run, counting from k=0 for the first digit after start, adds the eight-lane sum shifted left by N-1-k into the accumulator.
- R3: A start pulse clears the accumulator to 0 and captures N and M. Start takes priority over a digit presented in the same cycle, which is discarded. A start during a run abandons that run.
- R4: After exactly M effective digit steps the run ends. `res_valid` is high for exactly one cycle, in the cycle after the clock edge that takes the final digit, and at that point `result` equals the full sum.
- R5: `dig_valid` while no run is open has no effect: `result` stays unchanged and `res_valid` stays low.
- R6: Clamping of the settings: N=0 acts as 1 and N>8 acts as 8. M=0 acts as 1 and M>N acts as the effective N.
- R7: After reset, `result` is 0 and `busy` and `res_valid` are low.
- R8: `busy` is high from the cycle after start until the edge that takes the final digit, and it is low in the cycle where `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a run: clears the accumulator and captures the settings |
| prec_n | input | 4 | Stored weight width N |
| prec_m | input | 4 | Digits to process, M |
| dig_valid | input | 1 | A digit vector is present this cycle |
| dig_bits | input | 8 | One weight digit per lane (1 = +1, 0 = -1) |
| acts | input | 64 | Eight packed signed 8-bit activations, lane 0 in the low byte |
| busy | output | 1 | A run is open and accepting digits |
| res_valid | output | 1 | One-cycle strobe: the result is final |
| result | output | 22 | Signed accumulator |

## Verification
A wrong place-value counter changes the weight of every later step. A single run with known digits then shows a result that is off by a factor-of-two pattern, and this is visible at the very strobe that ends the run. A wrong digit-count register moves the strobe earlier or later by whole cycles, or drops it. The bench therefore checks the exact cycle of `res_valid` and of the fall of `busy`, and not only the final value. Lane sign faults show up on the extreme patterns, all -128 with -1 digits and all +127 with +1 digits, which also exercise the widest value the accumulator reaches.

// File: rtl/bitserial_mac_column.sv
module bitserial_mac_column #(
  parameter int LANES    = 8,
  parameter int ACT_W    = 8,
  parameter int ACC_W    = 22,
  parameter int MAX_BITS = 8,
  localparam int SH_W    = $clog2(MAX_BITS),
  localparam int CFG_W   = SH_W + 1,
  localparam int SUM_W   = ACT_W + 1 + $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CFG_W-1:0]       prec_n,
  input  logic [CFG_W-1:0]       prec_m,
  input  logic                   dig_valid,
  input  logic [LANES-1:0]       dig_bits,
  input  logic [LANES*ACT_W-1:0] acts,
  output logic                   busy,
  output logic                   res_valid,
  output logic [ACC_W-1:0]       result
);

  logic signed [SUM_W-1:0] lane_val [LANES];
  logic signed [SUM_W-1:0] col_sum;
  logic signed [ACC_W-1:0] addend;
  logic signed [ACC_W-1:0] acc;
  logic [SH_W-1:0]         shift;
  logic [CFG_W-1:0]        left;
  logic [CFG_W-1:0]        n_eff, m_eff;
  logic                    step;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [SUM_W-1:0] ext;
    assign ext = SUM_W'($signed(acts[i*ACT_W +: ACT_W]));
    assign lane_val[i] = dig_bits[i] ? ext : -ext;
  end

  always_comb begin
    col_sum = '0;
    for (int i = 0; i < LANES; i++) col_sum = col_sum + lane_val[i];
  end

  assign addend = ACC_W'(col_sum) <<< shift;

  assign n_eff = (prec_n == '0) ? CFG_W'(1) :
                 (prec_n > CFG_W'(MAX_BITS)) ? CFG_W'(MAX_BITS) : prec_n;
  assign m_eff = (prec_m == '0) ? CFG_W'(1) :
                 (prec_m > n_eff) ? n_eff : prec_m;

  assign step = busy && dig_valid && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      shift     <= '0;
      left      <= '0;
      busy      <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (start) begin
        acc   <= '0;
        shift <= SH_W'(n_eff - CFG_W'(1));
        left  <= m_eff;
        busy  <= 1'b1;
      end else if (step) begin
        acc   <= acc + addend;
        shift <= shift - SH_W'(1);
        left  <= left - CFG_W'(1);
        if (left == CFG_W'(1)) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
        end
      end
    end
  end

  assign result = acc;

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!busy && $past(busy)));

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (result == '0 && busy && !res_valid));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && !res_valid));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && left > CFG_W'(1)) |=> (shift == $past(shift) - SH_W'(1)));

  // R4
  open_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != '0));

endmodule

// File: tb/tb_bitserial_mac_column.sv
module tb_bitserial_mac_column;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  prec_n = 4'd8, prec_m = 4'd8;
  logic        dig_valid = 1'b0;
  logic [7:0]  dig_bits = '0;
  logic [63:0] acts = '0;
  logic        busy, res_valid;
  logic [21:0] result;

  int checks = 0, fails = 0;
  logic [7:0] wd [8];

  bitserial_mac_column dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_n(int n);
    return (n == 0) ? 1 : (n > 8) ? 8 : n;
  endfunction

  function automatic int eff_m(int n, int m);
    int ne = eff_n(n);
    return (m == 0) ? 1 : (m > ne) ? ne : m;
  endfunction

  function automatic longint ref_sum(int ne, int me);
    longint s = 0;
    for (int k = 0; k < me; k++) begin
      longint c = 0;
      for (int i = 0; i < 8; i++) begin
        longint a = longint'($signed(acts[i*8 +: 8]));
        c += wd[k][i] ? a : -a;
      end
      s += c * (longint'(1) << (ne - 1 - k));
    end
    return s;
  endfunction

  task automatic open_run(int n, int m, logic dv);
    @(negedge clk);
    start = 1'b1; prec_n = 4'(n); prec_m = 4'(m);
    dig_valid = dv; dig_bits = 8'hA5;
    @(negedge clk);
    start = 1'b0; dig_valid = 1'b0;
    chk("R3 clear", longint'($signed(result)), 0);
    chk("R8 busy after start", longint'(busy), 1);
  endtask

  task automatic feed_run(string req, int n, int m);
    int me = eff_m(n, m);
    longint exp = ref_sum(eff_n(n), me);
    for (int k = 0; k < me; k++) begin
      if (k > 0) chk("R8 busy mid run", longint'(busy), 1);
      dig_valid = 1'b1; dig_bits = wd[k];
      @(negedge clk);
    end
    dig_valid = 1'b0;
    chk({req, " R4 strobe"}, longint'(res_valid), 1);
    chk({req, " R8 busy low"}, longint'(busy), 0);
    chk({req, " R2 result"}, longint'($signed(result)), exp);
    @(negedge clk);
    chk("R4 strobe one cycle", longint'(res_valid), 0);
  endtask

  task automatic randomize_data();
    for (int k = 0; k < 8; k++) wd[k] = 8'($urandom);
    acts = {$urandom, $urandom};
  endtask

  task automatic t_reset();
    chk("R7 result", longint'(result), 0);
    chk("R7 busy", longint'(busy), 0);
    chk("R7 res_valid", longint'(res_valid), 0);
  endtask

  task automatic t_full();
    for (int r = 0; r < 12; r++) begin
      randomize_data();
      open_run(8, 8, 1'b0);
      feed_run("R1 full", 8, 8);
    end
  endtask

  task automatic t_trunc();
    int nm [5][2] = '{'{8,3}, '{8,1}, '{6,6}, '{5,2}, '{1,1}};
    for (int r = 0; r < 5; r++) begin
      randomize_data();
      open_run(nm[r][0], nm[r][1], 1'b0);
      feed_run("R2 truncated", nm[r][0], nm[r][1]);
    end
  endtask

  task automatic t_extreme();
    for (int k = 0; k < 8; k++) wd[k] = 8'h00;
    acts = {8{8'h80}};
    open_run(8, 8, 1'b0);
    feed_run("R1 neg128", 8, 8);
    chk("R1 neg128 value", longint'($signed(result)), 261120);
    for (int k = 0; k < 8; k++) wd[k] = 8'hFF;
    acts = {8{8'h7F}};
    open_run(8, 8, 1'b0);
    feed_run("R1 pos127", 8, 8);
    chk("R1 pos127 value", longint'($signed(result)), 259080);
  endtask

  task automatic t_clamp();
    int nm [4][2] = '{'{0,0}, '{12,15}, '{4,9}, '{3,0}};
    for (int r = 0; r < 4; r++) begin
      randomize_data();
      open_run(nm[r][0], nm[r][1], 1'b0);
      feed_run("R6 clamp", nm[r][0], nm[r][1]);
    end
  endtask

  task automatic t_restart();
    randomize_data();
    open_run(8, 8, 1'b0);
    dig_valid = 1'b1; dig_bits = 8'hFF; acts = {8{8'h7F}};
    @(negedge clk); @(negedge clk);
    dig_valid = 1'b0;
    randomize_data();
    open_run(4, 4, 1'b0);
    feed_run("R3 restart", 4, 4);
    randomize_data();
    open_run(5, 5, 1'b1);
    feed_run("R3 start over digit", 5, 5);
  endtask

  task automatic t_idle();
    longint held;
    randomize_data();
    open_run(3, 3, 1'b0);
    feed_run("R5 setup", 3, 3);
    held = longint'($signed(result));
    acts = {8{8'h7F}};
    for (int c = 0; c < 4; c++) begin
      dig_valid = 1'b1; dig_bits = 8'(c * 37);
      @(negedge clk);
      chk("R5 idle result", longint'($signed(result)), held);
      chk("R5 idle strobe", longint'(res_valid), 0);
    end
    dig_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full();
    t_trunc();
    t_extreme();
    t_clamp();
    t_restart();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule